// File: doc/BRIEF.md
# MII Receive Nibble Assembler

This block takes the four-bit receive path of a media independent interface, together with its valid and error strobes, and turns it into a byte stream. All sampling happens on the receive clock that the PHY recovers. While the valid strobe is high, the block hunts for the frame delimiter, which is a 0x5 nibble followed directly by a 0xD nibble. The valid strobe may rise late and cut off any number of leading preamble nibbles, so the hunt works with a preamble of any length, down to a single 0x5. After the delimiter, each pair of nibbles becomes one byte, taken low nibble first. Each byte carries flags that mark the first byte of the frame, the final complete byte, and an error on that final byte.

The block holds one byte back. A byte goes out when the byte after it completes. The held byte goes out with the last flag one cycle after the valid strobe is first sampled low. This lets the last flag mark the final complete byte without any lookahead on the line.

Outside a frame, the block decodes special signalling and reports low-power idle. It also passes the asynchronous carrier-sense and collision inputs through two-flop synchronizers. It reports a missing PHY when collision is high while carrier is low, a pair that a working PHY never drives.

Top module: `nib_rx_assembler`

## Requirements
- R1: After reset, every output is low.
- R2: No byte is produced until a 0x5 nibble is followed directly by a 0xD nibble while `rx_dv` is high. Any preamble length of at least one 0x5 nibble is accepted.
- R3: After the delimiter, the first nibble of each pair lands in `byte_data[3:0]` and the second in `byte_data[7:4]`. Bytes come out in the order they were received.
- R4: `byte_start` is high on the first byte of a frame and on no other byte.
- R5: `byte_last` is high on the final complete byte of the frame. That byte appears the cycle after `rx_dv` is first sampled low. Each earlier byte appears the cycle after the nibble that completes the byte following it is sampled.
- R6: If `rx_er` is high in any cycle where `rx_dv` is high, `byte_err` is raised on that frame's last byte. Error state does not carry into the next frame.
- R7: If a frame ends after an odd number of payload nibbles, the trailing nibble is dropped and `byte_err` is raised on the last byte.
- R8: A frame with no delimiter produces no bytes. A 0xD nibble that does not directly follow a 0x5 nibble is not a delimiter.
- R9: `lpi_active` is high in the cycle after `rxd` is sampled as 4'b0001 with `rx_dv` low and `rx_er` high. It is low after any other combination of these inputs.
- R10: `carrier` and `collision` follow `crs_async` and `col_async` through two synchronizing flops. `phy_absent` is high one cycle after synchronized `collision` is high while `carrier` is low.
- R11: `byte_err` is only raised together with `byte_last`. `byte_start` and `byte_last` are only raised together with `byte_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive clock recovered by the PHY |
| rst_n | input | 1 | Active-low synchronous reset |
| rxd | input | 4 | Receive nibble; bit 0 was received earliest |
| rx_dv | input | 1 | Receive data valid |
| rx_er | input | 1 | Receive error / out-of-frame signalling qualifier |
| crs_async | input | 1 | Carrier sense, asynchronous |
| col_async | input | 1 | Collision detect, asynchronous |
| byte_data | output | 8 | Assembled byte |
| byte_valid | output | 1 | `byte_data` holds a byte this cycle |
| byte_start | output | 1 | First byte of the frame |
| byte_last | output | 1 | Final complete byte of the frame |
| byte_err | output | 1 | Frame had a receive error or ended on an odd nibble |
| lpi_active | output | 1 | Low-power idle signalling seen |
| carrier | output | 1 | Synchronized carrier sense |
| collision | output | 1 | Synchronized collision |
| phy_absent | output | 1 | Collision without carrier: PHY missing |

## Verification
The bench sends frames with a full preamble and with a preamble cut down to one nibble. A design that counted preamble nibbles, or that started assembling on the valid strobe instead of on the delimiter, would shift every byte by a nibble. Single-byte frames test whether the first and last flags can both fall on the same byte. A design that looked ahead for the last flag would miss one of the two. Frames with a receive error, and frames that end on an odd nibble, must flag only the last byte. The clean frame sent right after them exposes error state that was never cleared. Line patterns with a stray 0xD, and low-power-idle look-alikes with the valid strobe high or a different code, would make a loose decoder emit bytes or raise idle when it should not.

// File: rtl/nib_rx_pkg.sv
package nib_rx_pkg;

    localparam int NIB_W  = 4;
    localparam int BYTE_W = 2 * NIB_W;

    typedef enum logic {
        ST_HUNT,
        ST_PAY
    } rx_state_e;

    typedef struct packed {
        logic              valid;
        logic              start;
        logic              last;
        logic              err;
        logic [BYTE_W-1:0] data;
    } rx_byte_t;

    typedef struct packed {
        rx_state_e         st;
        logic              saw_pre;
        logic              half;
        logic [NIB_W-1:0]  low;
        logic              pend_v;
        logic              pend_first;
        logic [BYTE_W-1:0] pend;
        logic              first;
        logic              err;
        rx_byte_t          out;
    } fr_state_t;

    typedef struct packed {
        logic lpi;
        logic absent;
    } st_state_t;

endpackage

// File: rtl/nib_rx_sync.sv
module nib_rx_sync #(
    parameter int STAGES = 2,
    parameter int W      = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [STAGES-1:0][W-1:0] chain_d, chain_q;

    always_comb begin
        chain_d[0] = din;
        for (int i = 1; i < STAGES; i++) begin
            chain_d[i] = chain_q[i-1];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= chain_d;
    end

    assign dout = chain_q[STAGES-1];
endmodule

// File: rtl/nib_rx_framer.sv
module nib_rx_framer
    import nib_rx_pkg::*;
#(
    parameter logic [NIB_W-1:0] PRE_NIB = 4'h5,
    parameter logic [NIB_W-1:0] SFD_NIB = 4'hD
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NIB_W-1:0] rxd,
    input  logic             rx_dv,
    input  logic             rx_er,
    output rx_byte_t         out
);
    fr_state_t fr_d, fr_q;

    always_comb begin
        fr_d     = fr_q;
        fr_d.out = '0;
        if (rx_dv) begin
            fr_d.err = fr_q.err | rx_er;
            if (fr_q.st == ST_HUNT) begin
                if (fr_q.saw_pre && (rxd == SFD_NIB)) begin
                    fr_d.st     = ST_PAY;
                    fr_d.half   = 1'b0;
                    fr_d.first  = 1'b1;
                    fr_d.pend_v = 1'b0;
                end
                fr_d.saw_pre = (rxd == PRE_NIB);
            end else if (!fr_q.half) begin
                fr_d.low  = rxd;
                fr_d.half = 1'b1;
            end else begin
                fr_d.half = 1'b0;
                if (fr_q.pend_v) begin
                    fr_d.out.valid = 1'b1;
                    fr_d.out.start = fr_q.pend_first;
                    fr_d.out.data  = fr_q.pend;
                end
                fr_d.pend       = {rxd, fr_q.low};
                fr_d.pend_first = fr_q.first;
                fr_d.pend_v     = 1'b1;
                fr_d.first      = 1'b0;
            end
        end else begin
            if ((fr_q.st == ST_PAY) && fr_q.pend_v) begin
                fr_d.out.valid = 1'b1;
                fr_d.out.start = fr_q.pend_first;
                fr_d.out.last  = 1'b1;
                fr_d.out.err   = fr_q.err | fr_q.half;
                fr_d.out.data  = fr_q.pend;
            end
            fr_d.st      = ST_HUNT;
            fr_d.saw_pre = 1'b0;
            fr_d.half    = 1'b0;
            fr_d.pend_v  = 1'b0;
            fr_d.first   = 1'b0;
            fr_d.err     = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) fr_q <= '0;
        else        fr_q <= fr_d;
    end

    assign out = fr_q.out;
endmodule

// File: rtl/nib_rx_status.sv
module nib_rx_status
    import nib_rx_pkg::*;
#(
    parameter logic [NIB_W-1:0] LPI_CODE    = 4'h1,
    parameter int               SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NIB_W-1:0] rxd,
    input  logic             rx_dv,
    input  logic             rx_er,
    input  logic             crs_async,
    input  logic             col_async,
    output logic             lpi_active,
    output logic             carrier,
    output logic             collision,
    output logic             phy_absent
);
    logic [1:0] line_s;
    st_state_t  st_d, st_q;

    nib_rx_sync #(.STAGES(SYNC_STAGES), .W(2)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  ({col_async, crs_async}),
        .dout (line_s)
    );

    always_comb begin
        st_d        = st_q;
        st_d.lpi    = !rx_dv && rx_er && (rxd == LPI_CODE);
        st_d.absent = line_s[1] && !line_s[0];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign lpi_active = st_q.lpi;
    assign carrier    = line_s[0];
    assign collision  = line_s[1];
    assign phy_absent = st_q.absent;
endmodule

// File: rtl/nib_rx_assembler.sv
module nib_rx_assembler
    import nib_rx_pkg::*;
#(
    parameter logic [NIB_W-1:0] PRE_NIB     = 4'h5,
    parameter logic [NIB_W-1:0] SFD_NIB     = 4'hD,
    parameter logic [NIB_W-1:0] LPI_CODE    = 4'h1,
    parameter int               SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NIB_W-1:0]  rxd,
    input  logic              rx_dv,
    input  logic              rx_er,
    input  logic              crs_async,
    input  logic              col_async,
    output logic [BYTE_W-1:0] byte_data,
    output logic              byte_valid,
    output logic              byte_start,
    output logic              byte_last,
    output logic              byte_err,
    output logic              lpi_active,
    output logic              carrier,
    output logic              collision,
    output logic              phy_absent
);
    rx_byte_t fr_out;

    nib_rx_framer #(.PRE_NIB(PRE_NIB), .SFD_NIB(SFD_NIB)) u_framer (
        .clk  (clk),
        .rst_n(rst_n),
        .rxd  (rxd),
        .rx_dv(rx_dv),
        .rx_er(rx_er),
        .out  (fr_out)
    );

    nib_rx_status #(.LPI_CODE(LPI_CODE), .SYNC_STAGES(SYNC_STAGES)) u_status (
        .clk       (clk),
        .rst_n     (rst_n),
        .rxd       (rxd),
        .rx_dv     (rx_dv),
        .rx_er     (rx_er),
        .crs_async (crs_async),
        .col_async (col_async),
        .lpi_active(lpi_active),
        .carrier   (carrier),
        .collision (collision),
        .phy_absent(phy_absent)
    );

    assign byte_data  = fr_out.data;
    assign byte_valid = fr_out.valid;
    assign byte_start = fr_out.start;
    assign byte_last  = fr_out.last;
    assign byte_err   = fr_out.err;
endmodule

// File: rtl/nib_rx_checker.sv
module nib_rx_checker
    import nib_rx_pkg::*;
#(
    parameter logic [NIB_W-1:0] LPI_CODE = 4'h1
) (
    input logic              clk,
    input logic              rst_n,
    input logic [NIB_W-1:0]  rxd,
    input logic              rx_dv,
    input logic              rx_er,
    input logic [BYTE_W-1:0] byte_data,
    input logic              byte_valid,
    input logic              byte_start,
    input logic              byte_last,
    input logic              byte_err,
    input logic              lpi_active,
    input logic              carrier,
    input logic              collision,
    input logic              phy_absent
);
    AST_ERR_WITH_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        byte_err |-> byte_last); // R11
    AST_START_WITH_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        byte_start |-> byte_valid); // R11
    AST_LAST_WITH_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        byte_last |-> byte_valid); // R11
    AST_LAST_AFTER_DV_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        byte_last |-> !$past(rx_dv)); // R5
    AST_MID_BYTE_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_valid && !byte_last) |-> $past(rx_dv)); // R5
    AST_LPI_DECODE: assert property (@(posedge clk) disable iff (!rst_n)
        lpi_active |-> $past(!rx_dv && rx_er && (rxd == LPI_CODE))); // R9
    AST_ABSENT_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
        phy_absent |-> $past(collision && !carrier)); // R10
endmodule

bind nib_rx_assembler nib_rx_checker #(.LPI_CODE(LPI_CODE)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .rxd       (rxd),
    .rx_dv     (rx_dv),
    .rx_er     (rx_er),
    .byte_data (byte_data),
    .byte_valid(byte_valid),
    .byte_start(byte_start),
    .byte_last (byte_last),
    .byte_err  (byte_err),
    .lpi_active(lpi_active),
    .carrier   (carrier),
    .collision (collision),
    .phy_absent(phy_absent)
);

// File: tb/sim_nib_rx_assembler.sv
module sim_nib_rx_assembler;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] rxd = 4'h0;
    logic       rx_dv = 1'b0;
    logic       rx_er = 1'b0;
    logic       crs_async = 1'b0;
    logic       col_async = 1'b0;
    logic [7:0] byte_data;
    logic       byte_valid, byte_start, byte_last, byte_err;
    logic       lpi_active, carrier, collision, phy_absent;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    logic [7:0] cap_d [32];
    logic       cap_s [32];
    logic       cap_l [32];
    logic       cap_e [32];
    int         cap_n = 0;

    always #10 clk = ~clk;

    nib_rx_assembler u0 (
        .clk(clk), .rst_n(rst_n), .rxd(rxd), .rx_dv(rx_dv), .rx_er(rx_er),
        .crs_async(crs_async), .col_async(col_async),
        .byte_data(byte_data), .byte_valid(byte_valid), .byte_start(byte_start),
        .byte_last(byte_last), .byte_err(byte_err), .lpi_active(lpi_active),
        .carrier(carrier), .collision(collision), .phy_absent(phy_absent)
    );

    always @(posedge clk) begin
        #1;
        if (byte_valid && cap_n < 32) begin
            cap_d[cap_n] = byte_data;
            cap_s[cap_n] = byte_start;
            cap_l[cap_n] = byte_last;
            cap_e[cap_n] = byte_err;
            cap_n = cap_n + 1;
        end
    end

    task automatic chk(input bit ok, input string rq, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
        end
    endtask

    task automatic drv(input bit dv, input bit er, input logic [3:0] d);
        @(negedge clk);
        rx_dv = dv;
        rx_er = er;
        rxd   = d;
    endtask

    function automatic logic [7:0] pay(input int i, input int seed);
        return 8'((i * 53) ^ 8'h3C ^ seed);
    endfunction

    task automatic run_frame(input int pre, input int nb, input bit odd,
                             input int er_nib, input int seed, input string rq);
        bit exp_err;
        cap_n = 0;
        for (int i = 0; i < pre; i++) drv(1'b1, 1'b0, 4'h5);
        drv(1'b1, 1'b0, 4'hD);
        for (int i = 0; i < nb; i++) begin
            logic [7:0] b;
            b = pay(i, seed);
            drv(1'b1, er_nib == 2 * i,     b[3:0]);
            drv(1'b1, er_nib == 2 * i + 1, b[7:4]);
        end
        if (odd) drv(1'b1, 1'b0, 4'h7);
        repeat (4) drv(1'b0, 1'b0, 4'h0);
        exp_err = (er_nib >= 0) || odd;
        chk(cap_n == nb, rq, "byte count", cap_n, nb);
        for (int i = 0; i < nb && i < cap_n; i++) begin
            chk(cap_d[i] == pay(i, seed), "R3", "byte data", cap_d[i], pay(i, seed));
            chk(cap_s[i] == (i == 0), "R4", "start flag", cap_s[i], i == 0);
            chk(cap_l[i] == (i == nb - 1), "R5", "last flag", cap_l[i], i == nb - 1);
            chk(cap_e[i] == ((i == nb - 1) && exp_err), rq, "err flag",
                cap_e[i], (i == nb - 1) && exp_err);
        end
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        chk({byte_valid, byte_start, byte_last, byte_err, lpi_active,
             carrier, collision, phy_absent} == 8'h0, "R1", "outputs in reset", 0, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk({byte_valid, lpi_active, carrier, collision, phy_absent} == 5'h0,
            "R1", "outputs after reset", 0, 0);
    endtask

    task automatic t_latency();
        // R5: one byte held back; it appears after the following byte completes
        cap_n = 0;
        drv(1'b1, 1'b0, 4'h5);
        drv(1'b1, 1'b0, 4'hD);
        drv(1'b1, 1'b0, 4'h1);
        drv(1'b1, 1'b0, 4'h2);
        drv(1'b1, 1'b0, 4'h3);
        chk(cap_n == 0, "R5", "no early output", cap_n, 0);
        drv(1'b1, 1'b0, 4'h4);
        @(posedge clk); #2;
        chk(cap_n == 1 && cap_d[0] == 8'h21 && !cap_l[0], "R5", "first byte timing",
            cap_n, 1);
        drv(1'b0, 1'b0, 4'h0);
        @(posedge clk); #2;
        chk(cap_n == 2 && cap_d[1] == 8'h43 && cap_l[1], "R5", "last byte timing",
            cap_n, 2);
        repeat (2) drv(1'b0, 1'b0, 4'h0);
    endtask

    task automatic t_no_sfd();
        logic [3:0] seq [8] = '{4'h5, 4'h5, 4'hA, 4'hD, 4'hD, 4'h6, 4'h5, 4'hE};
        cap_n = 0;
        for (int i = 0; i < 8; i++) drv(1'b1, 1'b0, seq[i]);
        repeat (3) drv(1'b0, 1'b0, 4'h0);
        chk(cap_n == 0, "R8", "bytes without delimiter", cap_n, 0);
    endtask

    task automatic t_lpi();
        drv(1'b0, 1'b1, 4'h1);
        @(posedge clk); #2;
        chk(lpi_active == 1'b1, "R9", "lpi on code", lpi_active, 1);
        drv(1'b0, 1'b1, 4'h3);
        @(posedge clk); #2;
        chk(lpi_active == 1'b0, "R9", "lpi other code", lpi_active, 0);
        drv(1'b1, 1'b1, 4'h1);
        @(posedge clk); #2;
        chk(lpi_active == 1'b0, "R9", "lpi with dv high", lpi_active, 0);
        drv(1'b0, 1'b0, 4'h1);
        @(posedge clk); #2;
        chk(lpi_active == 1'b0, "R9", "lpi without er", lpi_active, 0);
        drv(1'b0, 1'b0, 4'h0);
    endtask

    task automatic t_lines();
        @(negedge clk); crs_async = 1'b1; col_async = 1'b0;
        repeat (4) @(negedge clk);
        chk(carrier && !collision && !phy_absent, "R10", "carrier only",
            {carrier, collision, phy_absent}, 3'b100);
        col_async = 1'b1;
        repeat (4) @(negedge clk);
        chk(carrier && collision && !phy_absent, "R10", "collision with carrier",
            {carrier, collision, phy_absent}, 3'b110);
        crs_async = 1'b0;
        repeat (4) @(negedge clk);
        chk(!carrier && collision && phy_absent, "R10", "phy absent",
            {carrier, collision, phy_absent}, 3'b011);
        col_async = 1'b0;
        repeat (4) @(negedge clk);
        chk(!carrier && !collision && !phy_absent, "R10", "lines idle",
            {carrier, collision, phy_absent}, 3'b000);
    endtask

    initial begin
        t_reset();
        run_frame(7, 4, 1'b0, -1, 8'h11, "R2");
        run_frame(1, 3, 1'b0, -1, 8'h5A, "R2");
        run_frame(3, 1, 1'b0, -1, 8'h77, "R4");
        run_frame(2, 5, 1'b0, 3, 8'h21, "R6");
        run_frame(2, 2, 1'b0, -1, 8'h42, "R6");
        run_frame(4, 3, 1'b1, -1, 8'h09, "R7");
        t_latency();
        t_no_sfd();
        t_lpi();
        t_lines();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        #(20 * 150000);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule